// File: doc/BRIEF.md
# UART Interrupt Identification and Request Logic

This block decides which interrupt source a 16550-style serial port reports and drives its single interrupt request line. Five sources compete, and each is gated by one bit of a 4-bit enable register. The sources are line errors, receive character timeout, receive data available, transmit holding register empty and modem-status change. The winner's code appears in the identification byte, which the bus decoder returns on a read of that register.

The block also holds the state that register accesses change as a side effect. This covers the enable register itself and the transmit-empty pending flag. It also covers the transmit status bits (holding register empty, transmitter idle) and the four sticky line-error bits. The receive FIFO, the modem lines and the address decoder sit outside. They deliver the data-ready level, the FIFO fill count and trigger level, the timeout flag and the modem delta bits as inputs. They also deliver one-cycle strobes for each register access and transmitter event.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset the enable register reads 0, the identification byte reads 0x01, the status byte reads 0x60 (idle and holding-empty set, data-ready low), and `irq` is low.
- R2: Line errors win over everything. If enable bit 2 is set and any status bit 4:1 is set, the code is 0x6.
- R3: A pending receive timeout gives code 0xC when enable bit 0 is set, and it outranks data available. With enable bit 0 clear, the timeout is masked.
- R4: Data available gives code 0x4 when enable bit 0 is set and data-ready is high. FIFOs must also be disabled, or the fill count must be at or above the trigger level.
- R5: Transmit-empty gives code 0x2 when enable bit 1 is set and the pending flag is set. Modem change (enable bit 3 and any delta bit) gives code 0x0 and ranks lowest.
- R6: With no source active the code is 0x1. Identification bits 7:6 read 11 while FIFOs are enabled and 00 otherwise. `irq` is a register that shows, one cycle later, whether the code differed from 0x1.
- R7: An identification read while the code is 0x2 clears the pending flag. A read while another code shows leaves the flag alone.
- R8: A holding-register write clears the pending flag and clears status bits 5 (holding empty) and 6 (idle).
- R9: An enable write stores only data bits 3:0. If bit 1 changes, the pending flag becomes (new bit 1 AND holding-empty). If bit 1 does not change, the flag is kept.
- R10: A status read clears break (bit 4) and overrun (bit 1) and keeps parity (bit 2) and framing (bit 3). `line_err_set` bits [0] overrun, [1] parity, [2] framing, [3] break set their status bits. A set in the same cycle as the read survives.
- R11: A transmit FIFO reset sets holding-empty and sets the pending flag.
- R12: `tx_hold_empty` sets holding-empty and the pending flag. `tx_idle` sets the idle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable write data |
| iir_rd | input | 1 | Identification read strobe |
| lsr_rd | input | 1 | Status read strobe |
| thr_wr | input | 1 | Holding register write strobe |
| txf_reset | input | 1 | Transmit FIFO reset strobe |
| tx_hold_empty | input | 1 | Transmitter took the last held byte |
| tx_idle | input | 1 | Shift register finished |
| line_err_set | input | 4 | Error set pulses: [0] overrun, [1] parity, [2] framing, [3] break |
| rx_ready | input | 1 | Receive data ready level |
| fifo_en | input | 1 | FIFOs enabled |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level |
| rx_timeout | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem delta bits |
| ier_q | output | 4 | Stored enable bits |
| iir | output | 8 | Identification byte |
| lsr | output | 8 | Status byte |
| irq | output | 1 | Registered interrupt request |

## Verification
A status read and a fresh error pulse can land in the same cycle: the read tries to clear overrun while the receiver sets it again. The bench drives `lsr_rd` and `line_err_set[0]` together with parity already latched. It expects status 0x27 afterwards, so the new overrun and the old parity remain. A plain read that follows must then drop overrun to 0x25. A similar overlap is an enable write that keeps bit 1 while the pending flag is set. The bench judges it by the code staying 0x2 when a modem delta is raised at the same time.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_TXEMPTY = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_e;

    // sticky error bits, packed so that they line up with status bits 4:1
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } lerr_t;

    typedef struct packed {
        logic [3:0] en;
        logic       line_any;
        logic       tmo;
        logic       dr;
        logic       rx_at_trig;
        logic       fifo_en;
        logic       thr_pend;
        logic       mdelta;
    } enc_in_t;

    localparam int EN_RXD  = 0;
    localparam int EN_THR  = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;

    function automatic iid_e pick_id(enc_in_t s);
        iid_e r;
        if (s.en[EN_LINE] && s.line_any)                                 r = IID_LINE;
        else if (s.en[EN_RXD] && s.tmo)                                  r = IID_TIMEOUT;
        else if (s.en[EN_RXD] && s.dr && (!s.fifo_en || s.rx_at_trig))   r = IID_RXDATA;
        else if (s.en[EN_THR] && s.thr_pend)                             r = IID_TXEMPTY;
        else if (s.en[EN_MDM] && s.mdelta)                               r = IID_MODEM;
        else                                                             r = IID_NONE;
        return r;
    endfunction

endpackage

// File: rtl/uirq_line_status.sv
module uirq_line_status
    import uirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       thr_wr,
    input  logic       txf_reset,
    input  logic       tx_hold_empty,
    input  logic       tx_idle,
    input  logic       lsr_rd,
    input  logic [3:0] err_set,
    input  logic       rx_ready,
    output logic [7:0] lsr
);
    logic  thre_q, temt_q;
    lerr_t err_q, set_w, clr_w;

    assign set_w = lerr_t'(err_set);
    assign clr_w = '{brk: lsr_rd, frm: 1'b0, par: 1'b0, ovr: lsr_rd};

    always_ff @(posedge clk) begin
        if (rst) begin
            thre_q <= 1'b1;
            temt_q <= 1'b1;
            err_q  <= '0;
        end else begin
            if (txf_reset)          thre_q <= 1'b1;
            else if (thr_wr)        thre_q <= 1'b0;
            else if (tx_hold_empty) thre_q <= 1'b1;

            if (thr_wr)             temt_q <= 1'b0;
            else if (tx_idle)       temt_q <= 1'b1;

            err_q <= (err_q & ~clr_w) | set_w;
        end
    end

    assign lsr = {1'b0, temt_q, thre_q, err_q, rx_ready};

    // R10: a read clears overrun unless a new one arrives in the same cycle
    a_r10_read_clears_overrun: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !err_set[0]) |=> !lsr[1]);
    a_r10_parity_kept: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && lsr[2]) |=> lsr[2]);
    a_r8_write_clears_temt: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> !lsr[6]);

endmodule

// File: rtl/uirq_thr_pend.sv
module uirq_thr_pend
    import uirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ier_wr,
    input  logic [3:0] ier_wdata,
    input  logic       thr_wr,
    input  logic       txf_reset,
    input  logic       tx_hold_empty,
    input  logic       iir_rd,
    input  iid_e       cur_id,
    input  logic       thre,
    output logic [3:0] ier_q,
    output logic       pend
);
    logic thr_bit_flip;

    assign thr_bit_flip = ier_wr && (ier_wdata[EN_THR] != ier_q[EN_THR]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q <= '0;
            pend  <= 1'b0;
        end else begin
            if (ier_wr) ier_q <= ier_wdata;

            if (txf_reset)                         pend <= 1'b1;
            else if (thr_wr)                       pend <= 1'b0;
            else if (thr_bit_flip)                 pend <= ier_wdata[EN_THR] && thre;
            else if (tx_hold_empty)                pend <= 1'b1;
            else if (iir_rd && cur_id == IID_TXEMPTY) pend <= 1'b0;
        end
    end

    // R8: a holding-register write drops the pending flag
    a_r8_write_drops_pend: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !txf_reset) |=> !pend);
    // R7: reading the transmit-empty code acknowledges it
    a_r7_read_acks: assert property (@(posedge clk) disable iff (rst)
        (iir_rd && cur_id == IID_TXEMPTY && !txf_reset && !thr_bit_flip && !tx_hold_empty)
        |=> !pend);
    // R9: enabling with the holding register full leaves nothing pending
    a_r9_rearm_needs_thre: assert property (@(posedge clk) disable iff (rst)
        (thr_bit_flip && !thre && !txf_reset && !thr_wr) |=> !pend);

endmodule

// File: rtl/uirq_encoder.sv
module uirq_encoder
    import uirq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       en,
    input  logic             thr_pend,
    input  logic [7:0]       lsr,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic [3:0]       msr_delta,
    output iid_e             id,
    output logic [7:0]       iir
);
    localparam int LINE_LO = 1;
    localparam int LINE_HI = 4;

    enc_in_t s;

    always_comb begin
        s.en         = en;
        s.line_any   = |lsr[LINE_HI:LINE_LO];
        s.tmo        = rx_timeout;
        s.dr         = lsr[0];
        s.rx_at_trig = (rx_count >= rx_trig);
        s.fifo_en    = fifo_en;
        s.thr_pend   = thr_pend;
        s.mdelta     = |msr_delta;
        id           = pick_id(s);
        iir          = {{2{fifo_en}}, 2'b00, id};
    end

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uirq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ier_wr,
    input  logic [7:0]       ier_wdata,
    input  logic             iir_rd,
    input  logic             lsr_rd,
    input  logic             thr_wr,
    input  logic             txf_reset,
    input  logic             tx_hold_empty,
    input  logic             tx_idle,
    input  logic [3:0]       line_err_set,
    input  logic             rx_ready,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic [3:0]       msr_delta,
    output logic [3:0]       ier_q,
    output logic [7:0]       iir,
    output logic [7:0]       lsr,
    output logic             irq
);
    iid_e id_w;
    logic pend_w;

    uirq_line_status u_ls (
        .clk           (clk),
        .rst           (rst),
        .thr_wr        (thr_wr),
        .txf_reset     (txf_reset),
        .tx_hold_empty (tx_hold_empty),
        .tx_idle       (tx_idle),
        .lsr_rd        (lsr_rd),
        .err_set       (line_err_set),
        .rx_ready      (rx_ready),
        .lsr           (lsr)
    );

    uirq_thr_pend u_tp (
        .clk           (clk),
        .rst           (rst),
        .ier_wr        (ier_wr),
        .ier_wdata     (ier_wdata[3:0]),
        .thr_wr        (thr_wr),
        .txf_reset     (txf_reset),
        .tx_hold_empty (tx_hold_empty),
        .iir_rd        (iir_rd),
        .cur_id        (id_w),
        .thre          (lsr[5]),
        .ier_q         (ier_q),
        .pend          (pend_w)
    );

    uirq_encoder #(.CNT_W(CNT_W)) u_enc (
        .en         (ier_q),
        .thr_pend   (pend_w),
        .lsr        (lsr),
        .fifo_en    (fifo_en),
        .rx_count   (rx_count),
        .rx_trig    (rx_trig),
        .rx_timeout (rx_timeout),
        .msr_delta  (msr_delta),
        .id         (id_w),
        .iir        (iir)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= (id_w != IID_NONE);
    end

    // R6: request follows the previous cycle's code
    a_r6_irq_lags_code: assert property (@(posedge clk) disable iff (rst)
        irq == ($past(iir[3:0]) != 4'h1));
    // R11: transmit FIFO reset makes the holding register empty and pending
    a_r11_fifo_reset: assert property (@(posedge clk) disable iff (rst)
        txf_reset |=> (lsr[5] && pend_w));
    // R2: an enabled line error always owns the code
    a_r2_line_wins: assert property (@(posedge clk) disable iff (rst)
        (ier_q[2] && |lsr[4:1]) |-> (iir[3:0] == 4'h6));
    // R12: transmitter hand-off sets holding-empty
    a_r12_hold_empty: assert property (@(posedge clk) disable iff (rst)
        (tx_hold_empty && !thr_wr) |=> lsr[5]);

endmodule

// File: tb/sim_uart_irq_arbiter.sv
module sim_uart_irq_arbiter;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ier_wr = 0, iir_rd = 0, lsr_rd = 0, thr_wr = 0, txf_reset = 0;
    logic tx_hold_empty = 0, tx_idle = 0, rx_ready = 0, fifo_en = 0, rx_timeout = 0;
    logic [7:0] ier_wdata = '0;
    logic [3:0] line_err_set = '0, msr_delta = '0;
    logic [CNT_W-1:0] rx_count = '0, rx_trig = '0;
    logic [3:0] ier_q;
    logic [7:0] iir, lsr;
    logic irq;

    uart_irq_arbiter #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .iir_rd(iir_rd), .lsr_rd(lsr_rd), .thr_wr(thr_wr), .txf_reset(txf_reset),
        .tx_hold_empty(tx_hold_empty), .tx_idle(tx_idle), .line_err_set(line_err_set),
        .rx_ready(rx_ready), .fifo_en(fifo_en), .rx_count(rx_count), .rx_trig(rx_trig),
        .rx_timeout(rx_timeout), .msr_delta(msr_delta),
        .ier_q(ier_q), .iir(iir), .lsr(lsr), .irq(irq)
    );

    always #10 clk = ~clk;

    typedef struct {
        string      tag;
        logic [7:0] iir;
        logic [7:0] lsr;
        logic [3:0] ier;
        logic       irq;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // monitor: compares every queued expectation shortly after it is posted
    initial begin
        forever begin
            wait (sb.size() != 0);
            #2;
            while (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (iir !== e.iir || lsr !== e.lsr || ier_q !== e.ier || irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: iir=%h lsr=%h ier=%h irq=%b expected iir=%h lsr=%h ier=%h irq=%b",
                             e.tag, iir, lsr, ier_q, irq, e.iir, e.lsr, e.ier, e.irq);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
        ier_wr = 0; iir_rd = 0; lsr_rd = 0; thr_wr = 0; txf_reset = 0;
        tx_hold_empty = 0; tx_idle = 0; line_err_set = '0;
    endtask

    task automatic expect_out(string tag, logic [7:0] e_iir, logic [7:0] e_lsr,
                              logic [3:0] e_ier, logic e_irq);
        exp_t e;
        e.tag = tag; e.iir = e_iir; e.lsr = e_lsr; e.ier = e_ier; e.irq = e_irq;
        sb.push_back(e);
        #5;
    endtask

    task automatic wr_ier(logic [7:0] v);
        ier_wr = 1; ier_wdata = v;
        tick();
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        expect_out("R1 reset state", 8'h01, 8'h60, 4'h0, 1'b0);

        wr_ier(8'hF2);
        expect_out("R9 enable thr with empty holding / R6 irq lag", 8'h02, 8'h60, 4'h2, 1'b0);
        tick();
        expect_out("R6 irq follows code", 8'h02, 8'h60, 4'h2, 1'b1);

        iir_rd = 1; tick();
        expect_out("R7 read of tx-empty code acks", 8'h01, 8'h60, 4'h2, 1'b1);
        tick();
        expect_out("R6 irq drops", 8'h01, 8'h60, 4'h2, 1'b0);

        tx_hold_empty = 1; tick();
        expect_out("R12 hold-empty sets pending", 8'h02, 8'h60, 4'h2, 1'b0);
        thr_wr = 1; tick();
        expect_out("R8 write clears pending THRE TEMT", 8'h01, 8'h00, 4'h2, 1'b1);
        tx_hold_empty = 1; tick();
        expect_out("R12 hold-empty after write", 8'h02, 8'h20, 4'h2, 1'b0);
        tx_idle = 1; tick();
        expect_out("R12 idle sets TEMT", 8'h02, 8'h60, 4'h2, 1'b1);

        msr_delta = 4'b0001;
        wr_ier(8'h0A);
        expect_out("R5 tx-empty over modem / R9 flag kept", 8'h02, 8'h60, 4'hA, 1'b1);
        iir_rd = 1; tick();
        expect_out("R5 modem code after ack / R7", 8'h00, 8'h60, 4'hA, 1'b1);
        iir_rd = 1; tick();
        expect_out("R7 read of modem code leaves state", 8'h00, 8'h60, 4'hA, 1'b1);
        msr_delta = 4'b0000; tick();
        expect_out("R6 nothing pending", 8'h01, 8'h60, 4'hA, 1'b0);

        wr_ier(8'h08);
        wr_ier(8'h0A);
        expect_out("R9 re-arm with THRE", 8'h02, 8'h60, 4'hA, 1'b0);
        thr_wr = 1; tick();
        expect_out("R8 write while pending", 8'h01, 8'h00, 4'hA, 1'b1);
        wr_ier(8'h08);
        wr_ier(8'h0A);
        expect_out("R9 re-arm without THRE stays clear", 8'h01, 8'h00, 4'hA, 1'b0);

        txf_reset = 1; tick();
        expect_out("R11 fifo reset sets THRE and pending", 8'h02, 8'h20, 4'hA, 1'b0);

        rx_ready = 1;
        wr_ier(8'h0B);
        expect_out("R4 data ready fifos off", 8'h04, 8'h21, 4'hB, 1'b1);
        fifo_en = 1; rx_count = 5'd3; rx_trig = 5'd4; tick();
        expect_out("R4 below trigger / R6 fifo bits", 8'hC2, 8'h21, 4'hB, 1'b1);
        rx_count = 5'd4; tick();
        expect_out("R4 at trigger", 8'hC4, 8'h21, 4'hB, 1'b1);

        rx_timeout = 1; tick();
        expect_out("R3 timeout over data", 8'hCC, 8'h21, 4'hB, 1'b1);
        wr_ier(8'h0A);
        expect_out("R3 timeout masked by bit0", 8'hC2, 8'h21, 4'hA, 1'b1);
        rx_timeout = 0;

        wr_ier(8'h0E);
        line_err_set = 4'b0001; tick();
        expect_out("R2 overrun wins", 8'hC6, 8'h23, 4'hE, 1'b1);
        line_err_set = 4'b1010; tick();
        expect_out("R10 break and parity set", 8'hC6, 8'h37, 4'hE, 1'b1);
        lsr_rd = 1; tick();
        expect_out("R10 read clears break overrun keeps parity", 8'hC6, 8'h25, 4'hE, 1'b1);
        lsr_rd = 1; line_err_set = 4'b0001; tick();
        expect_out("R10 overrun in read cycle survives", 8'hC6, 8'h27, 4'hE, 1'b1);
        lsr_rd = 1; tick();
        expect_out("R10 later read clears it", 8'hC6, 8'h25, 4'hE, 1'b1);

        wr_ier(8'hFF);
        expect_out("R9 only low bits stored", 8'hC6, 8'h25, 4'hF, 1'b1);

        tick();
        wait (sb.size() == 0);
        #3;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule